// File: doc/BRIEF.md
# Fractional Pixel Clock Generator

This block derives a display pixel clock from one of two source clocks. It counts source ticks against a divider that has a 4-bit fractional part. Whole periods last either the integer part of the divider or one tick more. An accumulator chooses between the two, so the long-run output rate equals the source rate × 16 / divider. A separate field sets how long each period stays low.

The sources are modelled as clock-enable pulses (`core_tick`, `ext_tick`) inside a single `clk` domain. A control bit selects which one is counted. Software writes the divider, down-time and control fields through a plain write port, and reads back the active divider value. A release input starts and stops the counters.

The block has no data stream, so every pin is a plain control or status pin with no valid/ready handshake. A chip uses one instance per display interface.

Top module: `pixclk_frac_gen`

## Requirements
- R1: The divider register (address 0, bits [DIV_W-1:0]) holds 1/16-tick units: bits [3:0] are the fraction and the bits above are the integer part N. A 4-bit accumulator starts at zero on release. At each period start the fraction is added to it. The period lasts N+1 source ticks when that addition overflows, and N ticks otherwise.
- R2: A divider write below 0x10 is stored as 0x10. `div_rdback` shows the stored divider value one cycle after the write.
- R3: The down-time field (address 1, bits starting at bit 16) gives the low time D. Each period is high for its first N−D ticks and low for the rest.
- R4: When D is zero, or D is not less than N, the block uses floor(N/2) as the low time.
- R5: Control bit 0 (address 2) selects the counted source: 0 selects `core_tick` and 1 selects `ext_tick`. Pulses on the unselected source have no effect.
- R6: While `run_en` is low, `pix_stb` and `pix_lvl` are low one cycle later, and the counters and the accumulator are held cleared. The first selected tick after release starts a new period.
- R7: `pix_stb` is high for exactly one `clk` cycle, which is the cycle after the tick that starts a period. `pix_lvl` rises in that same cycle.
- R8: Divider and down-time writes made during a period do not change that period. They apply from the next period start.
- R9: After reset the divider is 0x10, the down time is 0, the source is `core_tick`, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_tick | input | 1 | Internal core clock enable pulse |
| ext_tick | input | 1 | External link clock enable pulse |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 divider, 1 down time, 2 control |
| cfg_wdata | input | 32 | Register write data |
| run_en | input | 1 | Counter release |
| pix_stb | output | 1 | One-cycle strobe at each pixel period start |
| pix_lvl | output | 1 | Pixel clock level |
| div_rdback | output | DIV_W | Stored divider value |

## Verification
The bench uses the default DIV_W of 16, which gives a 12-bit integer part. At that width small dividers such as 1.0, 2.5, 3.25 and 5.9375 show every fraction pattern within a few periods. These include the pattern where the accumulator carries on every period after the first, and the case N = 1 where the low time collapses to zero. The bench also switches the source while ticks arrive every other cycle. This separates the tick count from the cycle count, so a wrong source selection changes the measured length.

// File: rtl/pixclk_pkg.sv
`timescale 1ns/1ps
package pixclk_pkg;
  localparam int FRAC_W   = 4;
  localparam int DOWN_LSB = 16;
  localparam int MIN_DIV  = 16;

  typedef enum logic [1:0] {
    REG_DIV  = 2'd0,
    REG_DOWN = 2'd1,
    REG_CTRL = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/pixclk_cfg.sv
`timescale 1ns/1ps
module pixclk_cfg
  import pixclk_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  output logic [DIV_W-1:0] div_q,
  output logic [DIV_W-FRAC_W-1:0] down_eff,
  output logic             src_ext
);
  localparam int INT_W = DIV_W - FRAC_W;

  logic [INT_W-1:0] down_q;
  logic [INT_W-1:0] int_part;
  logic [DIV_W-1:0] wr_div;

  assign wr_div   = wdata[DIV_W-1:0];
  assign int_part = div_q[DIV_W-1:FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= DIV_W'(MIN_DIV);
      down_q  <= '0;
      src_ext <= 1'b0;
    end else if (we) begin
      case (reg_sel_e'(addr))
        REG_DIV:  div_q   <= (wr_div < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : wr_div;
        REG_DOWN: down_q  <= wdata[DOWN_LSB +: INT_W];
        REG_CTRL: src_ext <= wdata[0];
        default:  ;
      endcase
    end
  end

  // Fall back to half the integer period when the field is unusable.
  always_comb begin
    if (down_q == '0 || down_q >= int_part) down_eff = int_part >> 1;
    else                                   down_eff = down_q;
  end

  a_r2_div_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == REG_DIV) |=> (div_q >= DIV_W'(MIN_DIV)));
endmodule

// File: rtl/pixclk_frac_acc.sv
`timescale 1ns/1ps
module pixclk_frac_acc
  import pixclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;

  assign sum   = {1'b0, acc} + {1'b0, frac};
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else if (step)  acc <= sum[FRAC_W-1:0];
  end

  a_r6_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc == '0));
endmodule

// File: rtl/pixclk_frac_gen.sv
`timescale 1ns/1ps
module pixclk_frac_gen
  import pixclk_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_tick,
  input  logic             ext_tick,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             run_en,
  output logic             pix_stb,
  output logic             pix_lvl,
  output logic [DIV_W-1:0] div_rdback
);
  localparam int INT_W = DIV_W - FRAC_W;
  localparam int LEN_W = INT_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [INT_W-1:0] down_eff;
  logic             src_ext;
  logic             tick;
  logic             carry;
  logic             running;
  logic             boundary;
  logic [LEN_W-1:0] pos;
  logic [LEN_W-1:0] pos_nxt;
  logic [LEN_W-1:0] cur_len;
  logic [INT_W-1:0] high_len;
  logic [INT_W-1:0] int_part;

  pixclk_cfg #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .div_q(div_q), .down_eff(down_eff), .src_ext(src_ext)
  );

  pixclk_frac_acc u_acc (
    .clk(clk), .rst_n(rst_n), .clear(!run_en), .step(run_en && tick && boundary),
    .frac(div_q[FRAC_W-1:0]), .carry(carry)
  );

  assign tick       = src_ext ? ext_tick : core_tick;
  assign int_part   = div_q[DIV_W-1:FRAC_W];
  assign boundary   = !running || (pos == cur_len - LEN_W'(1));
  assign pos_nxt    = pos + LEN_W'(1);
  assign div_rdback = div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      pos      <= '0;
      cur_len  <= LEN_W'(1);
      high_len <= INT_W'(1);
      pix_lvl  <= 1'b0;
      pix_stb  <= 1'b0;
    end else if (!run_en) begin
      running  <= 1'b0;
      pos      <= '0;
      pix_lvl  <= 1'b0;
      pix_stb  <= 1'b0;
    end else begin
      pix_stb <= 1'b0;
      if (tick) begin
        if (boundary) begin
          running  <= 1'b1;
          pos      <= '0;
          cur_len  <= {1'b0, int_part} + LEN_W'(carry);
          high_len <= int_part - down_eff;
          pix_lvl  <= 1'b1;
          pix_stb  <= 1'b1;
        end else begin
          pos     <= pos_nxt;
          pix_lvl <= pos_nxt < {1'b0, high_len};
        end
      end
    end
  end

  a_r7_stb_with_level: assert property (@(posedge clk) disable iff (!rst_n)
    pix_stb |-> pix_lvl);
  a_r6_halt_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!pix_stb && !pix_lvl));
  a_r5_stb_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_stb) |-> $past(tick && run_en));
  a_r1_pos_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pos < cur_len));
endmodule

// File: tb/pixclk_frac_gen_tb.sv
`timescale 1ns/1ps
module pixclk_frac_gen_tb;
  localparam int DIV_W = 16;
  localparam int NV    = 5;

  // {divider write, down-time, len0, len1, len2, len3, high time, readback}
  typedef struct packed {
    logic [15:0] dv;
    logic [11:0] dn;
    logic [7:0]  l0, l1, l2, l3, hi;
    logic [15:0] rb;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{16'h0040, 12'd2, 8'd4, 8'd4, 8'd4, 8'd4, 8'd2, 16'h0040},
    '{16'h0028, 12'd1, 8'd2, 8'd3, 8'd2, 8'd3, 8'd1, 16'h0028},
    '{16'h0034, 12'd0, 8'd3, 8'd3, 8'd3, 8'd4, 8'd2, 16'h0034},
    '{16'h0005, 12'd0, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 16'h0010},
    '{16'h005F, 12'd9, 8'd5, 8'd6, 8'd6, 8'd6, 8'd3, 16'h005F}
  };

  logic clk = 0, rst_n = 0, core_tick = 0, ext_tick = 0, cfg_we = 0, run_en = 0;
  logic [1:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic pix_stb, pix_lvl;
  logic [DIV_W-1:0] div_rdback;
  logic ext_tog = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int lens[4];
  int hi0;

  always #2.5 clk = ~clk;

  always @(negedge clk) ext_tick <= ext_tog ? ~ext_tick : 1'b0;

  pixclk_frac_gen #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_tick(core_tick), .ext_tick(ext_tick),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .run_en(run_en),
    .pix_stb(pix_stb), .pix_lvl(pix_lvl), .div_rdback(div_rdback)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic measure();
    int t = 0;
    while (!pix_stb && t < 300) begin @(negedge clk); t++; end
    for (int k = 0; k < 4; k++) begin
      int len = 0, hi = 0;
      do begin
        hi += pix_lvl; len++;
        @(negedge clk);
      end while (!pix_stb && len < 1000);
      lens[k] = len;
      if (k == 0) hi0 = hi;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 stb", pix_stb, 0);
    check("R9 lvl", pix_lvl, 0);
    check("R9 rdback", div_rdback, 16);
    rst_n = 1;
    core_tick = 1;
    repeat (2) @(negedge clk);
    check("R6 idle stb", pix_stb, 0);

    // Table: R1 fraction, R2 clamp, R3/R4 low time
    for (int v = 0; v < NV; v++) begin
      run_en = 0;
      @(negedge clk);
      wr(2'd0, 32'(VEC[v].dv));
      check("R2 rdback", div_rdback, int'(VEC[v].rb));
      wr(2'd1, 32'(VEC[v].dn) << 16);
      run_en = 1;
      measure();
      check("R1 len0", lens[0], int'(VEC[v].l0));
      check("R1 len1", lens[1], int'(VEC[v].l1));
      check("R1 len2", lens[2], int'(VEC[v].l2));
      check("R1 len3", lens[3], int'(VEC[v].l3));
      check("R3 R4 high", hi0, int'(VEC[v].hi));
    end

    // R6: accumulator cleared on stop (0x28 leaves acc=8 here)
    run_en = 0; @(negedge clk);
    wr(2'd0, 32'h28); wr(2'd1, 32'h0);
    run_en = 1;
    measure();
    run_en = 0;
    @(negedge clk);
    check("R6 stop stb", pix_stb, 0);
    check("R6 stop lvl", pix_lvl, 0);
    run_en = 1;
    measure();
    check("R6 restart len0", lens[0], 2);
    check("R6 restart len1", lens[1], 3);

    // R8: mid-period write
    run_en = 0; @(negedge clk);
    wr(2'd0, 32'h40); wr(2'd1, 32'd2 << 16);
    run_en = 1;
    measure();
    wr(2'd0, 32'h80); wr(2'd1, 32'h0);
    begin
      int c = 0;
      while (!pix_stb && c < 50) begin @(negedge clk); c++; end
      check("R8 old period kept", c, 2);
    end
    measure();
    check("R8 new len", lens[0], 8);
    check("R8 new high", hi0, 4);

    // R5: unselected source ignored
    run_en = 0; @(negedge clk);
    wr(2'd0, 32'h30);
    core_tick = 0; ext_tog = 1;
    run_en = 1;
    begin
      int s = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); s += pix_stb; end
      check("R5 ext ignored", s, 0);
    end
    run_en = 0; @(negedge clk);
    wr(2'd2, 32'h1);
    core_tick = 1;
    run_en = 1;
    measure();
    check("R5 ext len", lens[1], 6);
    check("R5 ext high", hi0, 4);
    check("R7 stb width", lens[2], 6);

    // R7: strobe lasts a single cycle
    run_en = 0; @(negedge clk);
    wr(2'd2, 32'h0); ext_tog = 0;
    run_en = 1;
    begin
      int t = 0;
      while (!pix_stb && t < 50) begin @(negedge clk); t++; end
      check("R7 lvl with stb", pix_lvl, 1);
      @(negedge clk);
      check("R7 stb one cycle", pix_stb, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule